// File: doc/BRIEF.md
# Programmable Serial CRC Accelerator

This block computes a cyclic redundancy check over a stream of data words. Software picks the generator polynomial as a mask of up to 32 feedback taps and a length of 1 to 32 bits. It picks the data word width (8, 16 or 32 bits) separately from the polynomial length, and it picks whether each word is fed most-significant or least-significant bit first. Words are written into a fixed 16-byte store, which holds sixteen 8-bit, eight 16-bit or four 32-bit entries. A sequencer moves the words one at a time into a shift buffer, and the buffer drives a bit-serial feedback register at two bits per clock.

Software writes the starting value into the result register, pushes the words, and sets the run bit. The sequencer then empties the store word by word and signals completion. An interrupt flag is raised on either of two events, chosen by a configuration bit: the store being emptied, or the sequencer finishing. The flag stays set until software clears it.

The sequencer has three states. IDLE: if run is set and the store is not empty, it pops a word into the shift buffer and moves to SHIFT. SHIFT: it shifts two bits each cycle. On the last step of a word, it pops the next word and stays in SHIFT if run is set and the store is not empty, and otherwise it moves to DONE. DONE: it raises the shift-complete event for one cycle and returns to IDLE.

Top module: `crc_accel`

## Requirements
- R1: After reset the status register (address 4) reads 0x1, with only the empty bit set. The result register reads 0, and the irq output is low.
- R2: With n = CFG[4:0]+1, each data bit d is processed as follows. f = d XOR result[n-1]; the result shifts left by one; if f is 1 it is XORed with the POLY register (address 1); the result is then cut to its low n bits. In MSB-first order (CFG[7]=0), bit w-1 of each word is processed first.
- R3: With CFG[7]=1, each word is processed from bit 0 upward.
- R4: CFG[6:5] sets the word width: 0 gives 8 bits, 1 gives 16 bits, 2 or 3 give 32 bits. Bits of a pushed word above that width have no effect on the result.
- R5: A write to address 2 pushes one word. The store holds 16, 8 or 4 words for widths of 8, 16 or 32 bits. Status bit 1 shows full and status bit 0 shows empty.
- R6: A push into a full store is dropped and sets the overflow flag (status bit 2). The flag stays set until software writes 1 to status bit 2.
- R7: Words are processed only while the run bit CFG[9] is 1. The engine shifts two bits per clock, so a w-bit word takes w/2 cycles. Status bit 4 shows that the sequencer is not idle.
- R8: A write to address 3 loads the result register, which reads back the written value until shifting starts.
- R9: CFG[8]=1 raises the interrupt flag (status bit 3, and the irq pin) when the last stored word is popped. CFG[8]=0 raises it when the sequencer finishes.
- R10: The interrupt flag stays set until software writes 1 to status bit 3. If a raise and a clear fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_waddr | input | 3 | Write address (0 CFG, 1 POLY, 2 DATA, 3 RESULT, 4 STATUS) |
| bus_wdata | input | 32 | Write data |
| bus_raddr | input | 3 | Read address |
| bus_rdata | output | 32 | Read data, combinational from bus_raddr |
| irq | output | 1 | Interrupt flag |

## Verification
A write-one-to-clear of the interrupt flag can land in the same cycle that the selected event raises it. The bench provokes this by writing the run bit and, on the next cycle, the clear. With a single byte stored and the store-emptied source selected, the pop that empties the store falls on that second edge. The flag must read back as set, and a later clear with no event pending must clear it. The bench also times the two interrupt sources against each other with two stored bytes: at one sampling point the store-emptied source has already raised the flag while the other has not.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [2:0] {
        A_CFG    = 3'd0,
        A_POLY   = 3'd1,
        A_DATA   = 3'd2,
        A_RESULT = 3'd3,
        A_STAT   = 3'd4
    } addr_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_DONE
    } seq_state_e;

    // Field layout matches CFG[9:0]
    typedef struct packed {
        logic       run;
        logic       irq_on_empty;
        logic       lsb_first;
        logic [1:0] wsel;
        logic [4:0] plen_m1;
    } cfg_t;

    function automatic logic [2:0] width_bytes(input logic [1:0] wsel);
        case (wsel)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/crc_fifo.sv
module crc_fifo
    import crc_pkg::*;
#(
    parameter int unsigned BYTES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  wsel,
    input  logic        push,
    input  logic [31:0] push_data,
    input  logic        pop,
    output logic [31:0] pop_data,
    output logic        empty,
    output logic        full,
    output logic        drained
);
    localparam int PW = $clog2(BYTES);
    localparam int CW = PW + 1;

    logic [7:0]    mem [BYTES];
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] wb;
    logic          do_push, do_pop;

    assign wb      = CW'(width_bytes(wsel));
    assign empty   = (cnt_q == '0);
    assign full    = (int'(cnt_q) + int'(wb)) > int'(BYTES);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drained = do_pop && (cnt_q == wb);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + wb[PW-1:0];
            if (do_pop)  rp_q <= rp_q + wb[PW-1:0];
            cnt_q <= cnt_q + (do_push ? wb : '0) - (do_pop ? wb : '0);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            for (int k = 0; k < 4; k++) begin
                if (k < int'(wb)) mem[wp_q + PW'(k)] <= push_data[8*k +: 8];
            end
        end
    end

    always_comb begin
        pop_data = '0;
        for (int k = 0; k < 4; k++) begin
            if (k < int'(wb)) pop_data[8*k +: 8] = mem[rp_q + PW'(k)];
        end
    end

endmodule

// File: rtl/crc_engine.sv
module crc_engine
    import crc_pkg::*;
#(
    parameter int unsigned BPC = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_data,
    input  logic [1:0]  wsel,
    input  logic        lsb_first,
    input  logic        shift_en,
    input  logic [31:0] poly,
    input  logic [4:0]  plen_m1,
    input  logic        seed_we,
    input  logic [31:0] seed,
    output logic [31:0] crc
);
    logic [31:0] sbuf_q, crc_q;
    logic [31:0] chain [BPC+1];
    logic [5:0]  wbits;

    function automatic logic [31:0] lfsr_step(input logic [31:0] c, input logic d,
                                              input logic [31:0] p, input logic [4:0] m1);
        logic        fb;
        logic [31:0] mask;
        fb   = d ^ c[m1];
        mask = 32'hFFFF_FFFF >> (5'd31 - m1);
        return ((c << 1) ^ (fb ? p : 32'h0)) & mask;
    endfunction

    assign wbits    = {width_bytes(wsel), 3'b000};
    assign chain[0] = crc_q;

    for (genvar g = 0; g < BPC; g++) begin : g_step
        logic din;
        assign din        = lsb_first ? sbuf_q[g] : sbuf_q[31-g];
        assign chain[g+1] = lfsr_step(chain[g], din, poly, plen_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sbuf_q <= '0;
            crc_q  <= '0;
        end else begin
            if (load)
                sbuf_q <= lsb_first ? load_data : (load_data << (6'd32 - wbits));
            else if (shift_en)
                sbuf_q <= lsb_first ? (sbuf_q >> BPC) : (sbuf_q << BPC);
            if (seed_we)
                crc_q <= seed;
            else if (shift_en)
                crc_q <= chain[BPC];
        end
    end

    assign crc = crc_q;

endmodule

// File: rtl/crc_seq.sv
module crc_seq
    import crc_pkg::*;
#(
    parameter int unsigned BPC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       empty,
    input  logic [1:0] wsel,
    output logic       pop,
    output logic       load,
    output logic       shift_en,
    output logic       done_evt,
    output logic       busy
);
    localparam int MAXSTEPS = 32 / BPC;
    localparam int CNTW     = $clog2(MAXSTEPS + 1);

    seq_state_e      state_q, state_d;
    logic [CNTW-1:0] cnt_q, cnt_d, steps_m1;
    logic            fetch;

    assign steps_m1 = CNTW'((8 * int'(width_bytes(wsel))) / BPC - 1);
    assign fetch    = run && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (fetch) begin
                state_d = ST_SHIFT;
                cnt_d   = steps_m1;
            end
            ST_SHIFT: begin
                if (cnt_q != '0)  cnt_d   = cnt_q - 1'b1;
                else if (fetch)   cnt_d   = steps_m1;
                else              state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        pop      = 1'b0;
        shift_en = 1'b0;
        done_evt = 1'b0;
        unique case (state_q)
            ST_IDLE:  pop = fetch;
            ST_SHIFT: begin
                shift_en = 1'b1;
                pop      = (cnt_q == '0) && fetch;
            end
            ST_DONE:  done_evt = 1'b1;
            default:  ;
        endcase
        load = pop;
        busy = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/crc_accel.sv
module crc_accel
    import crc_pkg::*;
#(
    parameter int unsigned FIFO_BYTES = 16,
    parameter int unsigned BPC        = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [2:0]  bus_waddr,
    input  logic [31:0] bus_wdata,
    input  logic [2:0]  bus_raddr,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    cfg_t        cfg_q;
    logic [31:0] poly_q, crc_val, pop_data;
    logic        ovf_q, irq_q;
    logic        push_req, seed_we, ovf_clr, irq_clr, irq_set;
    logic        fifo_empty, fifo_full, drained;
    logic        pop, load, shift_en, done_evt, busy;

    assign push_req = bus_we && (bus_waddr == A_DATA);
    assign seed_we  = bus_we && (bus_waddr == A_RESULT);
    assign ovf_clr  = bus_we && (bus_waddr == A_STAT) && bus_wdata[2];
    assign irq_clr  = bus_we && (bus_waddr == A_STAT) && bus_wdata[3];
    assign irq_set  = cfg_q.irq_on_empty ? drained : done_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            poly_q <= '0;
            ovf_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (bus_we && bus_waddr == A_CFG)  cfg_q  <= cfg_t'(bus_wdata[9:0]);
            if (bus_we && bus_waddr == A_POLY) poly_q <= bus_wdata;
            if (push_req && fifo_full) ovf_q <= 1'b1;
            else if (ovf_clr)          ovf_q <= 1'b0;
            if (irq_set)      irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    crc_fifo #(.BYTES(FIFO_BYTES)) u_fifo (
        .clk(clk), .rst_n(rst_n), .wsel(cfg_q.wsel),
        .push(push_req), .push_data(bus_wdata),
        .pop(pop), .pop_data(pop_data),
        .empty(fifo_empty), .full(fifo_full), .drained(drained)
    );

    crc_seq #(.BPC(BPC)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .empty(fifo_empty),
        .wsel(cfg_q.wsel), .pop(pop), .load(load), .shift_en(shift_en),
        .done_evt(done_evt), .busy(busy)
    );

    crc_engine #(.BPC(BPC)) u_engine (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(pop_data),
        .wsel(cfg_q.wsel), .lsb_first(cfg_q.lsb_first), .shift_en(shift_en),
        .poly(poly_q), .plen_m1(cfg_q.plen_m1),
        .seed_we(seed_we), .seed(bus_wdata), .crc(crc_val)
    );

    always_comb begin
        case (bus_raddr)
            A_CFG:    bus_rdata = {22'b0, cfg_q};
            A_POLY:   bus_rdata = poly_q;
            A_RESULT: bus_rdata = crc_val;
            A_STAT:   bus_rdata = {27'b0, busy, irq_q, ovf_q, fifo_full, fifo_empty};
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = irq_q;

endmodule

// File: rtl/crc_accel_chk.sv
module crc_accel_chk (
    input logic clk,
    input logic rst_n,
    input logic fifo_empty,
    input logic fifo_full,
    input logic push_req,
    input logic pop,
    input logic ovf_q,
    input logic ovf_clr,
    input logic irq_q,
    input logic irq_clr,
    input logic irq_set
);
    a_r5_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
        push_req && fifo_full |=> ovf_q);

    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !ovf_clr |=> ovf_q);

    a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !fifo_empty);

    a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !irq_clr |=> irq_q);

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> irq_q);
endmodule

bind crc_accel crc_accel_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .push_req(push_req), .pop(pop), .ovf_q(ovf_q), .ovf_clr(ovf_clr),
    .irq_q(irq_q), .irq_clr(irq_clr), .irq_set(irq_set)
);

// File: tb/crc_accel_test.sv
`timescale 1ns/1ps
module crc_accel_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [2:0]  bus_raddr = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    crc_accel uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_waddr(bus_waddr),
        .bus_wdata(bus_wdata), .bus_raddr(bus_raddr), .bus_rdata(bus_rdata), .irq(irq)
    );

    typedef struct packed {
        logic [4:0]  plen_m1;
        logic [31:0] poly;
        logic [31:0] seed;
        logic [1:0]  wsel;
        logic        lsb;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{5'd31, 32'h04C1_1DB7, 32'hFFFF_FFFF, 2'd2, 1'b0, 32'h1234_5678},
        '{5'd31, 32'h04C1_1DB7, 32'hFFFF_FFFF, 2'd2, 1'b1, 32'hA5A5_F00F},
        '{5'd15, 32'h0000_1021, 32'h0000_FFFF, 2'd1, 1'b0, 32'hDEAD_BEEF},
        '{5'd7,  32'h0000_0007, 32'h0000_0000, 2'd0, 1'b1, 32'h1234_56C3},
        '{5'd4,  32'h0000_0005, 32'h0000_001F, 2'd0, 1'b0, 32'h0000_005A},
        '{5'd0,  32'h0000_0001, 32'h0000_0000, 2'd3, 1'b1, 32'hF0F0_F0F1}
    };

    function automatic logic [31:0] model(input logic [31:0] c, input logic [31:0] p,
                                          input int n, input logic [31:0] d,
                                          input int w, input bit lsb);
        logic [31:0] m;
        bit b, top;
        m = '0;
        for (int i = 0; i < n; i++) m[i] = 1'b1;
        for (int i = 0; i < w; i++) begin
            b   = lsb ? d[i] : d[w-1-i];
            top = c[n-1];
            c   = c << 1;
            if (b ^ top) c = c ^ p;
            c = c & m;
        end
        return c;
    endfunction

    function automatic int wbits(input logic [1:0] ws);
        return (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Caller is at a falling edge; the write takes the next rising edge.
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_waddr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_raddr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cfg(input bit run, input bit irqe, input bit lsb,
                       input logic [1:0] ws, input logic [4:0] pl);
        wr(3'd0, {22'b0, run, irqe, lsb, ws, pl});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r, exp;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        rd(3'd4, r); chk("R1 status", r, 32'h1);
        rd(3'd3, r); chk("R1 result", r, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2 R3 R4 R8 table walk
        for (int v = 0; v < 6; v++) begin
            cfg(1'b0, 1'b0, VECS[v].lsb, VECS[v].wsel, VECS[v].plen_m1);
            wr(3'd1, VECS[v].poly);
            wr(3'd3, VECS[v].seed);
            rd(3'd3, r); chk("R8 seed readback", r, VECS[v].seed);
            wr(3'd2, VECS[v].data);
            cfg(1'b1, 1'b0, VECS[v].lsb, VECS[v].wsel, VECS[v].plen_m1);
            idle(25);
            exp = model(VECS[v].seed, VECS[v].poly, int'(VECS[v].plen_m1) + 1,
                        VECS[v].data, wbits(VECS[v].wsel), VECS[v].lsb);
            rd(3'd3, r);
            chk(VECS[v].lsb ? "R3 lsb-first result" : "R2 msb-first result", r, exp);
            cfg(1'b0, 1'b0, VECS[v].lsb, VECS[v].wsel, VECS[v].plen_m1);
        end

        // R7 hold while stopped, then timing of a 32-bit word
        wr(3'd1, 32'h04C1_1DB7);
        cfg(1'b0, 1'b0, 1'b0, 2'd2, 5'd31);
        wr(3'd3, 32'h0000_0001);
        wr(3'd2, 32'hCAFE_0042);
        idle(10);
        rd(3'd4, r); chk("R7 word held while stopped", r & 32'h11, 32'h0);
        rd(3'd3, r); chk("R7 result unchanged while stopped", r, 32'h1);
        cfg(1'b1, 1'b0, 1'b0, 2'd2, 5'd31);
        idle(10);
        rd(3'd4, r); chk("R7 busy during 16 cycles", r[4], 1'b1);
        idle(15);
        rd(3'd4, r); chk("R7 idle after word", r[4], 1'b0);
        rd(3'd3, r); chk("R7 result", r, model(32'h1, 32'h04C1_1DB7, 32, 32'hCAFE_0042, 32, 1'b0));
        cfg(1'b0, 1'b0, 1'b0, 2'd2, 5'd31);

        // R5 capacity per width
        for (int ws = 0; ws < 3; ws++) begin
            int depth;
            depth = 16 / (wbits(2'(ws)) / 8);
            cfg(1'b0, 1'b0, 1'b0, 2'(ws), 5'd7);
            for (int i = 0; i < depth; i++) begin
                rd(3'd4, r); chk("R5 not full before last push", r[1], 1'b0);
                wr(3'd2, 32'(i));
            end
            rd(3'd4, r); chk("R5 full at capacity", r[2:0], 3'b010);
            cfg(1'b1, 1'b0, 1'b0, 2'(ws), 5'd7);
            idle(80);
            rd(3'd4, r); chk("R5 empty after drain", r[1:0], 2'b01);
            cfg(1'b0, 1'b0, 1'b0, 2'(ws), 5'd7);
        end

        // R6 overflow drop, sticky flag, clear
        wr(3'd1, 32'h07);
        cfg(1'b0, 1'b0, 1'b0, 2'd0, 5'd7);
        wr(3'd3, 32'h0);
        exp = 32'h0;
        for (int i = 0; i < 16; i++) begin
            wr(3'd2, 32'(i + 1));
            exp = model(exp, 32'h07, 8, 32'(i + 1), 8, 1'b0);
        end
        wr(3'd2, 32'hFF);
        rd(3'd4, r); chk("R6 overflow set", r[2:0], 3'b110);
        cfg(1'b1, 1'b0, 1'b0, 2'd0, 5'd7);
        idle(80);
        rd(3'd3, r); chk("R6 dropped word not processed", r, exp);
        rd(3'd4, r); chk("R6 overflow sticky", r[2], 1'b1);
        wr(3'd4, 32'h4);
        rd(3'd4, r); chk("R6 overflow cleared", r[2], 1'b0);
        cfg(1'b0, 1'b0, 1'b0, 2'd0, 5'd7);

        // R9 store-emptied source
        wr(3'd4, 32'h8);
        wr(3'd2, 32'h11); wr(3'd2, 32'h22);
        cfg(1'b1, 1'b1, 1'b0, 2'd0, 5'd7);
        idle(6);
        rd(3'd4, r); chk("R9 empty source raises before finish", r[4:3], 2'b11);
        chk("R9 irq pin", {31'b0, irq}, 32'h1);
        idle(6);
        rd(3'd4, r); chk("R10 flag held", r[3], 1'b1);
        wr(3'd4, 32'h8);
        rd(3'd4, r); chk("R10 flag cleared", r[3], 1'b0);
        chk("R10 irq pin low", {31'b0, irq}, 32'h0);
        cfg(1'b0, 1'b1, 1'b0, 2'd0, 5'd7);

        // R9 shift-complete source
        wr(3'd2, 32'h33); wr(3'd2, 32'h44);
        cfg(1'b1, 1'b0, 1'b0, 2'd0, 5'd7);
        idle(6);
        rd(3'd4, r); chk("R9 complete source quiet mid-run", r[4:3], 2'b10);
        idle(6);
        rd(3'd4, r); chk("R9 complete source raised", r[4:3], 2'b01);
        wr(3'd4, 32'h8);
        cfg(1'b0, 1'b1, 1'b0, 2'd0, 5'd7);

        // R10 raise and clear in the same cycle
        wr(3'd2, 32'h55);
        cfg(1'b1, 1'b1, 1'b0, 2'd0, 5'd7);
        wr(3'd4, 32'h8);
        rd(3'd4, r); chk("R10 raise beats clear", r[3], 1'b1);
        idle(8);
        wr(3'd4, 32'h8);
        rd(3'd4, r); chk("R10 later clear", r[3], 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule